// File: doc/BRIEF.md
# Chip-Select Serial Command Receiver

This block sits between a host's three-wire serial link (chip enable, shift clock, data) and the configuration state of a dot-matrix display controller. While the enable is high, the host shifts in an 8-bit device address and then up to 144 instruction bits. All three serial lines are resynchronised into the system clock domain. A data bit is taken on every rising edge of the shift clock. The instruction is decoded and committed only when the enable falls.

The top bits of the frame form the opcode. One opcode is four bits long and the rest are five bits long. The block applies the fields of a decoded frame to its configuration registers and raises a one-cycle `cmd_valid` with the command code. For the three memory-write commands it issues a one-cycle strobe, a target select and the raw payload instead of touching any memory. A power-save flag limits which commands are accepted.

Frame capture runs on a five-state machine:
- `ST_IDLE`: waits for the enable to go high and clears the bit buffer.
- `ST_ADDR`: collects the eight address bits.
- `ST_DATA`: collects instruction bits.
- `ST_SKIP`: ignores the rest of a frame whose address does not match.
- `ST_COMMIT`: presents the frame for one cycle.

Transitions:
- `ST_IDLE` goes to `ST_ADDR` when the enable is high.
- `ST_ADDR` goes to `ST_DATA` when the eighth address bit completes a match, and to `ST_SKIP` when it does not.
- `ST_ADDR` and `ST_SKIP` return to `ST_IDLE` when the enable goes low.
- `ST_DATA` goes to `ST_COMMIT` when the enable goes low.
- `ST_COMMIT` always returns to `ST_IDLE`.

Top module: `lcdrx_top`

## Requirements
- R1: While `rst_n` is low, every configuration output and `cmd_valid` is 0 and serial traffic has no effect.
- R2: The first 8 bits after the enable rises are the device address, least significant bit first, and must equal 4EH. Instruction bit Dn is the n-th bit after the address. After the enable falls, the configuration updates and `cmd_valid` pulses for exactly one cycle with `cmd_code`, where 1 = technique, 2 = on/off, 3 = scroll, 4 = start address, 5/6/7 = memory writes and 8 = contrast.
- R3: Reception works whether the shift clock idles low or high between frames.
- R4: Technique command, opcode {D143..D139} = 10000:
  - `duty_sel` = {D137,D136}.
  - `frame_fast` = D138.
  - `layout_sel` = {D129,D128}.
  - `font_wide` = D130.
- R5: On/off command, opcode {D143..D140} = 0100:
  - `digit_en`[k] = D(120+k).
  - `show_main` = D136, `show_aux` = D137.
  - `blank` = D138, `pwr_save` = D139.
- R6: Scroll command, opcode 11000:
  - `hscroll` = D122..D120.
  - `vscroll` = D131..D128.
  - `scroll_right` = D136, `scroll_down` = D137.
- R7: Start-address command, opcode 00100:
  - `start_addr` = D133..D128.
  - `dot_col` = D114..D112.
  - `dot_row` = D123..D120.
- R8: Memory-write commands:
  - Opcode 10100 gives `mem_wr_sel` = 1, 01100 gives 2, and 11100 gives 3.
  - Each pulses `mem_wr_stb` together with `cmd_valid`, with `mem_wr_data`[k] = Dk for k = 0..138.
  - No other command raises `mem_wr_stb`.
- R9: Contrast command, opcode 00010: `contrast_lvl` = D131..D128 and `contrast_on` = D134.
- R10: While `pwr_save` is 1, only the on/off and contrast commands are accepted. Any other frame changes nothing and gives no pulse.
- R11: A frame with a wrong address, an unknown opcode, or too few bits to fill the opcode changes no output and gives no pulse. Buffer bits that were not received read as 0.
- R12: Bits past the 144th within one enable window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; disables reception |
| ser_en | input | 1 | Serial chip enable |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| duty_sel | output | 2 | Drive duty select |
| frame_fast | output | 1 | Doubled frame rate |
| layout_sel | output | 2 | Line structure select |
| font_wide | output | 1 | Six-dot font width |
| digit_en | output | 16 | Per-digit enables |
| show_main | output | 1 | Main character data shown |
| show_aux | output | 1 | Auxiliary segment data shown |
| blank | output | 1 | Drivers forced off |
| pwr_save | output | 1 | Power-save mode |
| hscroll | output | 3 | Horizontal scroll amount in dots |
| vscroll | output | 4 | Vertical scroll amount in dots |
| scroll_right | output | 1 | Horizontal direction is right |
| scroll_down | output | 1 | Vertical direction is down |
| start_addr | output | 6 | Display RAM start address |
| dot_col | output | 3 | Horizontal dot offset |
| dot_row | output | 4 | Vertical dot offset |
| contrast_lvl | output | 4 | Contrast level field |
| contrast_on | output | 1 | Contrast circuit enable |
| mem_wr_stb | output | 1 | Memory-write strobe |
| mem_wr_sel | output | 2 | Memory-write target |
| mem_wr_data | output | 139 | Memory-write payload D0..D138 |
| cmd_valid | output | 1 | Accepted-command pulse |
| cmd_code | output | 4 | Accepted command code |

## Verification
On every cycle, the assertions check four things:
- A commit happens only with the enable low.
- `cmd_valid` lasts one cycle and follows a commit.
- No configuration output moves without a `cmd_valid`.
- A memory strobe always comes with a memory-write code, and power save lets only on/off and contrast codes through.

Only the bench scenarios can show the rest:
- Each field lands in the right output bits.
- The address match and the opcode decode are correct.
- Both shift-clock idle levels work.
- Short and over-long frames are handled as required.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
    localparam int FRAME_BITS = 144;
    localparam int OP_LO      = FRAME_BITS - 5;
    localparam int PAY_W      = OP_LO;
    localparam int CFG_W      = 53;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP, ST_COMMIT
    } rx_state_e;

    typedef enum logic [3:0] {
        CMD_NONE     = 4'd0,
        CMD_TECH     = 4'd1,
        CMD_ONOFF    = 4'd2,
        CMD_SCROLL   = 4'd3,
        CMD_START    = 4'd4,
        CMD_WR_TEXT  = 4'd5,
        CMD_WR_AUX   = 4'd6,
        CMD_WR_GLYPH = 4'd7,
        CMD_CONTRAST = 4'd8
    } cmd_e;
endpackage

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/lcdrx_capture.sv
module lcdrx_capture
    import lcdrx_pkg::*;
#(
    parameter int         ADDR_BITS = 8,
    parameter logic [7:0] DEV_ADDR  = 8'h4E
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_s,
    input  logic                  sclk_s,
    input  logic                  dat_s,
    output logic [FRAME_BITS-1:0] frame_q,
    output logic                  frame_done
);
    localparam int CNT_W  = $clog2(FRAME_BITS + 1);
    localparam int AIDX_W = $clog2(ADDR_BITS);

    rx_state_e            state, nxt;
    logic [CNT_W-1:0]     cnt;
    logic [ADDR_BITS-2:0] addr_q;
    logic                 sclk_d;
    logic                 rise;
    logic                 addr_last;
    logic                 addr_hit;

    assign rise      = sclk_s & ~sclk_d;
    assign addr_last = (cnt == CNT_W'(ADDR_BITS - 1));
    assign addr_hit  = ({dat_s, addr_q} == DEV_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (en_s) nxt = ST_ADDR;
            ST_ADDR:   if (!en_s) nxt = ST_IDLE;
                       else if (rise && addr_last) nxt = addr_hit ? ST_DATA : ST_SKIP;
            ST_DATA:   if (!en_s) nxt = ST_COMMIT;
            ST_SKIP:   if (!en_s) nxt = ST_IDLE;
            ST_COMMIT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            cnt     <= '0;
            addr_q  <= '0;
            frame_q <= '0;
        end else begin
            sclk_d <= sclk_s;
            unique case (state)
                ST_IDLE: begin
                    cnt     <= '0;
                    frame_q <= '0;
                end
                ST_ADDR: if (en_s && rise) begin
                    if (addr_last) begin
                        cnt <= '0;
                    end else begin
                        addr_q[cnt[AIDX_W-1:0]] <= dat_s;
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: if (en_s && rise && cnt < CNT_W'(FRAME_BITS)) begin
                    frame_q[cnt] <= dat_s;
                    cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign frame_done = (state == ST_COMMIT);
endmodule

// File: rtl/lcdrx_decode.sv
module lcdrx_decode
    import lcdrx_pkg::*;
(
    input  logic [4:0] op,
    output cmd_e       cmd,
    output logic [1:0] wr_sel
);
    always_comb begin
        cmd = CMD_NONE;
        if (op[4:1] == 4'b0100) begin
            cmd = CMD_ONOFF;
        end else begin
            unique case (op)
                5'b10000: cmd = CMD_TECH;
                5'b11000: cmd = CMD_SCROLL;
                5'b00100: cmd = CMD_START;
                5'b10100: cmd = CMD_WR_TEXT;
                5'b01100: cmd = CMD_WR_AUX;
                5'b11100: cmd = CMD_WR_GLYPH;
                5'b00010: cmd = CMD_CONTRAST;
                default:  cmd = CMD_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (cmd)
            CMD_WR_TEXT:  wr_sel = 2'd1;
            CMD_WR_AUX:   wr_sel = 2'd2;
            CMD_WR_GLYPH: wr_sel = 2'd3;
            default:      wr_sel = 2'd0;
        endcase
    end
endmodule

// File: rtl/lcdrx_top.sv
module lcdrx_top
    import lcdrx_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'h4E,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_en,
    input  logic             ser_clk,
    input  logic             ser_dat,
    output logic [1:0]       duty_sel,
    output logic             frame_fast,
    output logic [1:0]       layout_sel,
    output logic             font_wide,
    output logic [15:0]      digit_en,
    output logic             show_main,
    output logic             show_aux,
    output logic             blank,
    output logic             pwr_save,
    output logic [2:0]       hscroll,
    output logic [3:0]       vscroll,
    output logic             scroll_right,
    output logic             scroll_down,
    output logic [5:0]       start_addr,
    output logic [2:0]       dot_col,
    output logic [3:0]       dot_row,
    output logic [3:0]       contrast_lvl,
    output logic             contrast_on,
    output logic             mem_wr_stb,
    output logic [1:0]       mem_wr_sel,
    output logic [PAY_W-1:0] mem_wr_data,
    output logic             cmd_valid,
    output logic [3:0]       cmd_code
);
    logic [2:0]            sync_q;
    logic                  en_s;
    logic [FRAME_BITS-1:0] fr;
    logic                  frame_done;
    cmd_e                  cmd;
    logic [1:0]            wr_sel;
    logic                  accept;

    lcdrx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_en, ser_clk, ser_dat}), .q(sync_q)
    );

    assign en_s = sync_q[2];

    lcdrx_capture #(.ADDR_BITS(8), .DEV_ADDR(DEV_ADDR)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .en_s(en_s), .sclk_s(sync_q[1]), .dat_s(sync_q[0]),
        .frame_q(fr), .frame_done(frame_done)
    );

    lcdrx_decode u_dec (
        .op(fr[FRAME_BITS-1:OP_LO]), .cmd(cmd), .wr_sel(wr_sel)
    );

    always_comb begin
        accept = frame_done && (cmd != CMD_NONE);
        if (pwr_save && cmd != CMD_ONOFF && cmd != CMD_CONTRAST) accept = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_sel <= '0;   frame_fast <= 1'b0; layout_sel <= '0;  font_wide <= 1'b0;
            digit_en <= '0;   show_main <= 1'b0;  show_aux <= 1'b0;  blank <= 1'b0;
            pwr_save <= 1'b0; hscroll <= '0;      vscroll <= '0;
            scroll_right <= 1'b0; scroll_down <= 1'b0;
            start_addr <= '0; dot_col <= '0;      dot_row <= '0;
            contrast_lvl <= '0; contrast_on <= 1'b0;
            mem_wr_stb <= 1'b0; mem_wr_sel <= '0; mem_wr_data <= '0;
            cmd_valid <= 1'b0;  cmd_code <= CMD_NONE;
        end else begin
            cmd_valid  <= accept;
            cmd_code   <= accept ? cmd : CMD_NONE;
            mem_wr_stb <= accept && (wr_sel != 2'd0);
            mem_wr_sel <= accept ? wr_sel : 2'd0;
            if (accept) begin
                unique case (cmd)
                    CMD_TECH: begin
                        layout_sel <= fr[129:128];
                        font_wide  <= fr[130];
                        duty_sel   <= fr[137:136];
                        frame_fast <= fr[138];
                    end
                    CMD_ONOFF: begin
                        digit_en  <= fr[135:120];
                        show_main <= fr[136];
                        show_aux  <= fr[137];
                        blank     <= fr[138];
                        pwr_save  <= fr[139];
                    end
                    CMD_SCROLL: begin
                        hscroll      <= fr[122:120];
                        vscroll      <= fr[131:128];
                        scroll_right <= fr[136];
                        scroll_down  <= fr[137];
                    end
                    CMD_START: begin
                        dot_col    <= fr[114:112];
                        dot_row    <= fr[123:120];
                        start_addr <= fr[133:128];
                    end
                    CMD_CONTRAST: begin
                        contrast_lvl <= fr[131:128];
                        contrast_on  <= fr[134];
                    end
                    CMD_WR_TEXT, CMD_WR_AUX, CMD_WR_GLYPH:
                        mem_wr_data <= fr[PAY_W-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lcdrx_checker.sv
module lcdrx_checker
    import lcdrx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en_s,
    input logic             frame_done,
    input logic             cmd_valid,
    input logic [3:0]       cmd_code,
    input logic             mem_wr_stb,
    input logic             pwr_save,
    input logic [CFG_W-1:0] cfg
);
    p_commit_enable_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !en_s);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_pulse_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(frame_done));

    p_hold_config_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(cfg));

    p_strobe_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_stb |-> (cmd_valid && cmd_code >= 4'd5 && cmd_code <= 4'd7));

    p_powersave_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $past(pwr_save)) |-> (cmd_code == 4'd2 || cmd_code == 4'd8));
endmodule

bind lcdrx_top lcdrx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .frame_done(frame_done),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .mem_wr_stb(mem_wr_stb),
    .pwr_save(pwr_save),
    .cfg({duty_sel, frame_fast, layout_sel, font_wide, digit_en, show_main,
          show_aux, blank, pwr_save, hscroll, vscroll, scroll_right,
          scroll_down, start_addr, dot_col, dot_row, contrast_lvl, contrast_on})
);

// File: tb/lcdrx_top_test.sv
module lcdrx_top_test;
    logic clk = 1'b0, rst_n = 1'b0, ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic [1:0] duty_sel, layout_sel, mem_wr_sel;
    logic frame_fast, font_wide, show_main, show_aux, blank, pwr_save;
    logic [15:0] digit_en;
    logic [2:0] hscroll, dot_col;
    logic [3:0] vscroll, dot_row, contrast_lvl, cmd_code;
    logic scroll_right, scroll_down, contrast_on, mem_wr_stb, cmd_valid;
    logic [5:0] start_addr;
    logic [138:0] mem_wr_data;

    lcdrx_top uut (.*);

    always #2 clk = ~clk;

    int tests = 0, fails = 0;

    typedef struct {
        logic [3:0]   code;
        logic [1:0]   sel;
        logic [138:0] pay;
    } exp_t;
    exp_t q[$];
    exp_t e;
    logic [143:0] f;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] code, input logic [1:0] sel, input logic [138:0] pay);
        exp_t x;
        x.code = code; x.sel = sel; x.pay = pay;
        q.push_back(x);
    endtask

    // monitor: compares each accepted-command pulse against the scoreboard
    initial forever begin
        @(negedge clk);
        if (rst_n && cmd_valid) begin
            if (q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R11 unexpected pulse actual=%h expected=none", cmd_code);
            end else begin
                e = q.pop_front();
                chk("R2 cmd_code", 64'(cmd_code), 64'(e.code));
                chk("R8 mem_wr_stb", 64'(mem_wr_stb), 64'(e.sel != 2'd0));
                if (e.sel != 2'd0) begin
                    chk("R8 mem_wr_sel", 64'(mem_wr_sel), 64'(e.sel));
                    tests++;
                    if (mem_wr_data !== e.pay) begin
                        fails++;
                        $display("FAIL R8 payload actual=%h expected=%h", mem_wr_data, e.pay);
                    end
                end
            end
        end
    end

    task automatic sbit(input logic v);
        ser_clk = 1'b0; ser_dat = v;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] a, input logic [143:0] fr, input int n, input bit idle_hi);
        @(negedge clk);
        ser_clk = idle_hi;
        repeat (4) @(negedge clk);
        ser_en = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) sbit(a[i]);
        for (int i = 0; i < n; i++) sbit((i < 144) ? fr[i] : 1'b1);
        if (!idle_hi) begin
            ser_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        ser_en = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        #600000;
        fails++; tests++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state, and a frame sent during reset has no effect
        repeat (3) @(negedge clk);
        f = '0; f[143:139] = 5'b10000; f[129] = 1'b1; f[130] = 1'b1; f[137] = 1'b1; f[138] = 1'b1;
        send(8'h4E, f, 144, 1'b0);
        chk("R1 duty_sel in reset", 64'(duty_sel), 0);
        chk("R1 digit_en in reset", 64'(digit_en), 0);
        chk("R1 cmd_valid in reset", 64'(cmd_valid), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 technique, shift clock idling low (R3)
        push(4'd1, 2'd0, '0);
        send(8'h4E, f, 144, 1'b0);
        chk("R4 duty_sel", 64'(duty_sel), 64'(2'b10));
        chk("R4 frame_fast", 64'(frame_fast), 1);
        chk("R4 layout_sel", 64'(layout_sel), 64'(2'b10));
        chk("R4 font_wide", 64'(font_wide), 1);

        // R5 on/off, shift clock idling high (R3)
        f = '0; f[143:140] = 4'b0100; f[135:120] = 16'hA5C3; f[136] = 1'b1; f[138] = 1'b1;
        push(4'd2, 2'd0, '0);
        send(8'h4E, f, 144, 1'b1);
        chk("R3 R5 digit_en", 64'(digit_en), 64'h A5C3);
        chk("R5 show_main/show_aux/blank/pwr_save",
            64'({show_main, show_aux, blank, pwr_save}), 64'(4'b1010));

        // R6 scroll with extra bits beyond 144 (R12)
        f = '0; f[143:139] = 5'b11000; f[122:120] = 3'd5; f[131:128] = 4'd9; f[136] = 1'b1;
        push(4'd3, 2'd0, '0);
        send(8'h4E, f, 150, 1'b0);
        chk("R6 R12 hscroll", 64'(hscroll), 5);
        chk("R6 R12 vscroll", 64'(vscroll), 9);
        chk("R6 R12 directions", 64'({scroll_right, scroll_down}), 64'(2'b10));
        f = '0; f[143:139] = 5'b11000; f[122:120] = 3'd3; f[131:128] = 4'd4; f[137] = 1'b1;
        push(4'd3, 2'd0, '0);
        send(8'h4E, f, 144, 1'b1);
        chk("R6 second scroll", 64'({hscroll, vscroll, scroll_right, scroll_down}),
            64'({3'd3, 4'd4, 1'b0, 1'b1}));

        // R7 start address
        f = '0; f[143:139] = 5'b00100; f[133:128] = 6'h2E; f[114:112] = 3'd3; f[123:120] = 4'd10;
        push(4'd4, 2'd0, '0);
        send(8'h4E, f, 144, 1'b0);
        chk("R7 start_addr", 64'(start_addr), 64'h2E);
        chk("R7 dot_col/dot_row", 64'({dot_col, dot_row}), 64'({3'd3, 4'd10}));

        // R8 memory writes
        f = '0; f[143:139] = 5'b10100; f[7:0] = 8'hC7; f[13:8] = 6'h15; f[138] = 1'b1;
        push(4'd5, 2'd1, f[138:0]);
        send(8'h4E, f, 144, 1'b0);
        chk("R8 start_addr untouched", 64'(start_addr), 64'h2E);
        f = '0; f[143:139] = 5'b01100; f[79:0] = 80'h1234_5678_9ABC_DEF0_0F1E;
        push(4'd6, 2'd2, f[138:0]);
        send(8'h4E, f, 144, 1'b1);
        f = '0; f[143:139] = 5'b11100; f[52:0] = 53'h1F_0A0B_0C0D_0E0F; f[100] = 1'b1;
        push(4'd7, 2'd3, f[138:0]);
        send(8'h4E, f, 144, 1'b0);

        // R9 contrast
        f = '0; f[143:139] = 5'b00010; f[131:128] = 4'd9; f[134] = 1'b1;
        push(4'd8, 2'd0, '0);
        send(8'h4E, f, 144, 1'b0);
        chk("R9 contrast", 64'({contrast_lvl, contrast_on}), 64'({4'd9, 1'b1}));

        // R11 wrong address, unknown opcode, short frame
        f = '0; f[143:139] = 5'b10000; f[136] = 1'b1;
        send(8'h4F, f, 144, 1'b0);
        chk("R11 wrong address", 64'(duty_sel), 64'(2'b10));
        f = '0; f[139] = 1'b1; f[135:120] = 16'h0001;
        send(8'h4E, f, 144, 1'b0);
        chk("R11 unknown opcode", 64'(digit_en), 64'hA5C3);
        f = '0; f[143:139] = 5'b10000; f[136] = 1'b1;
        send(8'h4E, f, 100, 1'b1);
        chk("R11 short frame", 64'(duty_sel), 64'(2'b10));

        // R10 power save gating
        f = '0; f[143:140] = 4'b0100; f[135:120] = 16'h00FF; f[136] = 1'b1; f[137] = 1'b1; f[139] = 1'b1;
        push(4'd2, 2'd0, '0);
        send(8'h4E, f, 144, 1'b0);
        chk("R10 enter power save", 64'({pwr_save, digit_en}), 64'({1'b1, 16'h00FF}));
        f = '0; f[143:139] = 5'b10000; f[136] = 1'b1;
        send(8'h4E, f, 144, 1'b0);
        chk("R10 technique blocked", 64'(duty_sel), 64'(2'b10));
        f = '0; f[143:139] = 5'b11000; f[122:120] = 3'd1;
        send(8'h4E, f, 144, 1'b0);
        chk("R10 scroll blocked", 64'(hscroll), 3);
        f = '0; f[143:139] = 5'b00010; f[131:128] = 4'd3;
        push(4'd8, 2'd0, '0);
        send(8'h4E, f, 144, 1'b1);
        chk("R10 contrast accepted", 64'({contrast_lvl, contrast_on}), 64'({4'd3, 1'b0}));
        f = '0; f[143:140] = 4'b0100; f[135:120] = 16'h8001;
        push(4'd2, 2'd0, '0);
        send(8'h4E, f, 144, 1'b0);
        chk("R10 leave power save", 64'({pwr_save, digit_en}), 64'({1'b0, 16'h8001}));

        chk("R2 scoreboard drained", 64'(q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule